// File: doc/BRIEF.md
# Accumulator Multicycle Processor Core

This block is a small stored-program computer. It has one 16-bit accumulator and a 4096-word memory, which it holds itself and addresses by word. The core steps through fetch, decode and execute as a chain of single-cycle register transfers. Each instruction word carries a 4-bit opcode in bits 15..12 and a 12-bit direct address in bits 11..0. Arithmetic works on 16-bit two's complement values and wraps modulo 2^16.

Bytes arrive on an 8-bit input port. Each byte is qualified by a one-cycle valid strobe and is latched into an internal input holding register. The core sends bytes out on an 8-bit port with a one-cycle write strobe. A halted flag shows when execution has stopped. The memory image is written, and can be read back, through a backdoor port. Loading is meant to happen while reset is held.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, `halted` and `out_we` are low. After `rst_n` is released, execution starts from address 0x000.
- R2: LOAD (opcode 0x1) copies M[X] into AC. STORE (opcode 0x2) writes AC to M[X]. X is instruction bits 11..0.
- R3: ADD (opcode 0x3) sets AC to AC+M[X] and SUBT (opcode 0x4) sets AC to AC-M[X]. Both wrap modulo 2^16.
- R4: ADDI (opcode 0xB) reads M[X] and uses its low 12 bits as the operand address. It then adds the word at that address to AC.
- R5: SKIPCOND (opcode 0x8) skips the next instruction when the test chosen by instruction bits 11..10 holds: 00 means AC negative, 01 means AC zero, 10 means AC positive and non-zero. Code 11 never skips.
- R6: JUMP (opcode 0x9) continues execution at X. CLEAR (opcode 0xA) sets AC to 0.
- R7: JNS (opcode 0x0) writes the zero-extended address of the instruction that follows it into M[X], then continues at X+1. No other word is written.
- R8: INPUT (opcode 0x5) stalls until a byte has been latched from `in_data` by an `in_valid` pulse. It then loads that byte, zero-extended, into AC.
- R9: OUTPUT (opcode 0x6) places AC bits 7..0 on `out_data` and raises `out_we` for exactly one cycle. Each OUTPUT gives one pulse.
- R10: HALT (opcode 0x7) raises `halted`, which stays high until reset. After HALT no memory write and no output pulse occur, and PC and AC hold their values.
- R11: Opcodes 0xC to 0xF change nothing, and execution moves on to the next instruction.
- R12: With `bd_we` high, `bd_wdata` is written to M[`bd_addr`] at the clock edge. `bd_rdata` always shows M[`bd_addr`] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | One-cycle strobe that latches `in_data` |
| out_data | output | 8 | Last byte written by OUTPUT |
| out_we | output | 1 | One-cycle pulse per OUTPUT |
| halted | output | 1 | High once HALT has executed |
| bd_we | input | 1 | Backdoor memory write enable |
| bd_addr | input | 12 | Backdoor word address |
| bd_wdata | input | 16 | Backdoor write data |
| bd_rdata | output | 16 | Backdoor read data, combinational |

## Verification
The in-line properties check the following on every cycle:
- HALT is sticky and freezes PC, AC, memory writes and output pulses.
- Each output pulse lasts one cycle.
- A taken skip advances PC by exactly one, and JNS lands on its target plus one.
- A LOAD result equals the fetched operand.
- A pending INPUT leaves AC untouched until a byte arrives.
- The backdoor never writes during execution.

Some results only a running program can show: wrapped arithmetic, indirect operand selection, every skip code including the never-skip code, the stored return address, and an input byte supplied well after the core began waiting. The bench's program covers these and checks them through the byte stream and backdoor reads of memory.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPW = 4;

  typedef enum logic [3:0] {
    OP_JNS    = 4'h0,
    OP_LOAD   = 4'h1,
    OP_STORE  = 4'h2,
    OP_ADD    = 4'h3,
    OP_SUBT   = 4'h4,
    OP_INPUT  = 4'h5,
    OP_OUTPUT = 4'h6,
    OP_HALT   = 4'h7,
    OP_SKIP   = 4'h8,
    OP_JUMP   = 4'h9,
    OP_CLEAR  = 4'hA,
    OP_ADDI   = 4'hB
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2
  } alu_op_e;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_EXEC   = 4'd2,
    ST_READ   = 4'd3,
    ST_POINT  = 4'd4,
    ST_READ2  = 4'd5,
    ST_ALU    = 4'd6,
    ST_WRITE  = 4'd7,
    ST_HALT   = 4'd8
  } state_e;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] res
);

  function automatic logic [DW-1:0] alu_fn(input alu_op_e f,
                                            input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    case (f)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      default: return b;
    endcase
  endfunction

  assign res = alu_fn(op, acc, opnd);

endmodule

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata,
  input  logic          bd_we,
  input  logic [AW-1:0] bd_addr,
  input  logic [DW-1:0] bd_wdata,
  output logic [DW-1:0] bd_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words_q [DEPTH];

  always_ff @(posedge clk) begin
    if (bd_we)        words_q[bd_addr]   <= bd_wdata;
    else if (core_we) words_q[core_addr] <= core_wdata;
  end

  assign core_rdata = words_q[core_addr];
  assign bd_rdata   = words_q[bd_addr];

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int AW  = 12,
  parameter int DW  = 16,
  parameter int IOW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IOW-1:0] in_data,
  input  logic           in_valid,
  output logic [IOW-1:0] out_data,
  output logic           out_we,
  output logic           halted,
  input  logic           bd_we,
  input  logic [AW-1:0]  bd_addr,
  input  logic [DW-1:0]  bd_wdata,
  output logic [DW-1:0]  bd_rdata
);

  localparam int AZ = DW - AW;
  localparam int IZ = DW - IOW;

  state_e         st_q;
  logic [DW-1:0]  ac_q, mbr_q, ir_q;
  logic [AW-1:0]  pc_q, mar_q;
  logic [IOW-1:0] inreg_q, outreg_q;
  logic           in_full_q, out_we_q, halted_q;

  logic [OPW-1:0] op;
  logic [AW-1:0]  ir_addr;
  logic [DW-1:0]  mem_rdata, alu_y;
  alu_op_e        alu_sel;

  function automatic logic skip_hit(input logic [1:0] code, input logic [DW-1:0] a);
    case (code)
      2'b00:   return a[DW-1];
      2'b01:   return (a == '0);
      2'b10:   return !a[DW-1] && (a != '0);
      default: return 1'b0;
    endcase
  endfunction

  assign op      = ir_q[DW-1 -: OPW];
  assign ir_addr = ir_q[AW-1:0];

  // named internal events
  logic exec_now, skip_taken, in_take, in_wait, core_we, jns_done;
  assign exec_now   = (st_q == ST_EXEC);
  assign skip_taken = exec_now && (op == OP_SKIP) && skip_hit(ir_q[AW-1 -: 2], ac_q);
  assign in_take    = exec_now && (op == OP_INPUT) && in_full_q;
  assign in_wait    = exec_now && (op == OP_INPUT) && !in_full_q;
  assign core_we    = (st_q == ST_WRITE);
  assign jns_done   = core_we && (op == OP_JNS);

  always_comb begin
    case (op)
      OP_ADD, OP_ADDI: alu_sel = ALU_ADD;
      OP_SUBT:         alu_sel = ALU_SUB;
      default:         alu_sel = ALU_PASS;
    endcase
  end

  acc_cpu_alu #(.DW(DW)) u_alu (
    .op   (alu_sel),
    .acc  (ac_q),
    .opnd (mbr_q),
    .res  (alu_y)
  );

  acc_cpu_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk        (clk),
    .core_we    (core_we),
    .core_addr  (mar_q),
    .core_wdata (mbr_q),
    .core_rdata (mem_rdata),
    .bd_we      (bd_we),
    .bd_addr    (bd_addr),
    .bd_wdata   (bd_wdata),
    .bd_rdata   (bd_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_FETCH;
      pc_q      <= '0;
      mar_q     <= '0;
      ac_q      <= '0;
      mbr_q     <= '0;
      ir_q      <= '0;
      inreg_q   <= '0;
      in_full_q <= 1'b0;
      outreg_q  <= '0;
      out_we_q  <= 1'b0;
      halted_q  <= 1'b0;
    end else begin
      out_we_q <= 1'b0;
      if (in_valid) begin
        inreg_q   <= in_data;
        in_full_q <= 1'b1;
      end else if (in_take) begin
        in_full_q <= 1'b0;
      end
      case (st_q)
        ST_FETCH: begin
          mar_q <= pc_q;
          st_q  <= ST_DECODE;
        end
        ST_DECODE: begin
          ir_q <= mem_rdata;
          pc_q <= pc_q + 1'b1;
          st_q <= ST_EXEC;
        end
        ST_EXEC: begin
          st_q <= ST_FETCH;
          case (op)
            OP_LOAD, OP_ADD, OP_SUBT, OP_ADDI: begin
              mar_q <= ir_addr;
              st_q  <= ST_READ;
            end
            OP_STORE: begin
              mar_q <= ir_addr;
              mbr_q <= ac_q;
              st_q  <= ST_WRITE;
            end
            OP_JNS: begin
              mar_q <= ir_addr;
              mbr_q <= {{AZ{1'b0}}, pc_q};
              st_q  <= ST_WRITE;
            end
            OP_INPUT: begin
              if (in_full_q) ac_q <= {{IZ{1'b0}}, inreg_q};
              else           st_q <= ST_EXEC;
            end
            OP_OUTPUT: begin
              outreg_q <= ac_q[IOW-1:0];
              out_we_q <= 1'b1;
            end
            OP_HALT: begin
              halted_q <= 1'b1;
              st_q     <= ST_HALT;
            end
            OP_SKIP:  if (skip_taken) pc_q <= pc_q + 1'b1;
            OP_JUMP:  pc_q <= ir_addr;
            OP_CLEAR: ac_q <= '0;
            default:  ;
          endcase
        end
        ST_READ: begin
          mbr_q <= mem_rdata;
          st_q  <= (op == OP_ADDI) ? ST_POINT : ST_ALU;
        end
        ST_POINT: begin
          mar_q <= mbr_q[AW-1:0];
          st_q  <= ST_READ2;
        end
        ST_READ2: begin
          mbr_q <= mem_rdata;
          st_q  <= ST_ALU;
        end
        ST_ALU: begin
          ac_q <= alu_y;
          st_q <= ST_FETCH;
        end
        ST_WRITE: begin
          if (op == OP_JNS) pc_q <= mar_q + 1'b1;
          st_q <= ST_FETCH;
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  assign out_data = outreg_q;
  assign out_we   = out_we_q;
  assign halted   = halted_q;

  // ---------------- assertions ----------------
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q);

  p_halt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> ($stable(pc_q) && $stable(ac_q) && !core_we && !out_we_q));

  p_out_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_we_q |=> !out_we_q);

  p_skip_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    skip_taken |=> (pc_q == $past(pc_q) + 1'b1));

  p_jns_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    jns_done |=> (pc_q == $past(mar_q) + 1'b1));

  p_input_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |=> (st_q == ST_EXEC) && $stable(ac_q));

  p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ALU) && (op == OP_LOAD)) |=> (ac_q == $past(mbr_q)));

  p_backdoor_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bd_we && core_we));

endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  in_data;
  logic        in_valid;
  logic [7:0]  out_data;
  logic        out_we;
  logic        halted;
  logic        bd_we;
  logic [11:0] bd_addr;
  logic [15:0] bd_wdata;
  logic [15:0] bd_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int n_out = 0;
  int cyc   = 0;
  int pulse_cyc = -1;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_we(out_we), .halted(halted),
    .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata), .bd_rdata(bd_rdata)
  );

  function automatic logic [15:0] enc(input logic [3:0] opc, input logic [11:0] x);
    return {opc, x};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = a; bd_wdata = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic expect_byte(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard on every output pulse
  always @(negedge clk) begin
    if (mon_en && rst_n && out_we) begin
      if (halted) chk("R10 output after halt", 1, 0);
      if (exp_q.size() == 0) begin
        chk("R9 unexpected output byte", {24'h0, out_data}, 32'hFFFF_FFFF);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        n_out++;
        chk("R9 output byte", {24'h0, out_data}, {24'h0, e});
        if (n_out == 6) chk("R8 input stalls until byte given", (pulse_cyc >= 0 && cyc > pulse_cyc), 1);
      end
    end
  end

  // input driver: supply the byte well after the core starts waiting
  initial begin
    in_valid = 1'b0;
    in_data  = 8'h00;
    wait (n_out == 5);
    repeat (30) @(negedge clk);
    in_data  = 8'h90;
    in_valid = 1'b1;
    pulse_cyc = cyc;
    @(negedge clk);
    in_valid = 1'b0;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk("watchdog expired", 1, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0; bd_we = 1'b0; bd_addr = '0; bd_wdata = '0;
    // program
    poke(12'h000, enc(4'h1, 12'h100)); // LOAD 100
    poke(12'h001, enc(4'h3, 12'h101)); // ADD 101
    poke(12'h002, enc(4'h6, 12'h000)); // OUTPUT
    poke(12'h003, enc(4'h4, 12'h102)); // SUBT 102
    poke(12'h004, enc(4'h2, 12'h110)); // STORE 110
    poke(12'h005, enc(4'h6, 12'h000)); // OUTPUT
    poke(12'h006, enc(4'h8, 12'h000)); // SKIP neg (taken)
    poke(12'h007, enc(4'h6, 12'h000)); // skipped
    poke(12'h008, enc(4'h8, 12'h800)); // SKIP pos (not taken)
    poke(12'h009, enc(4'hA, 12'h000)); // CLEAR
    poke(12'h00A, enc(4'h8, 12'h400)); // SKIP zero (taken)
    poke(12'h00B, enc(4'h7, 12'h000)); // skipped HALT
    poke(12'h00C, enc(4'h8, 12'hC00)); // SKIP code 11 (never)
    poke(12'h00D, enc(4'hB, 12'h103)); // ADDI 103
    poke(12'h00E, enc(4'h6, 12'h000)); // OUTPUT
    poke(12'h00F, enc(4'hC, 12'h123)); // no-op
    poke(12'h010, enc(4'h6, 12'h000)); // OUTPUT
    poke(12'h011, enc(4'h0, 12'h120)); // JNS 120
    poke(12'h012, enc(4'h5, 12'h000)); // INPUT
    poke(12'h013, enc(4'h6, 12'h000)); // OUTPUT
    poke(12'h014, enc(4'h3, 12'h105)); // ADD 105
    poke(12'h015, enc(4'h2, 12'h111)); // STORE 111
    poke(12'h016, enc(4'h9, 12'h018)); // JUMP 018
    poke(12'h017, enc(4'h6, 12'h000)); // skipped
    poke(12'h018, enc(4'h7, 12'h000)); // HALT
    poke(12'h120, 16'h0000);
    poke(12'h121, enc(4'h1, 12'h106)); // LOAD 106
    poke(12'h122, enc(4'h6, 12'h000)); // OUTPUT
    poke(12'h123, enc(4'h9, 12'h012)); // JUMP 012
    // data
    poke(12'h100, 16'h0005);
    poke(12'h101, 16'h0003);
    poke(12'h102, 16'h000A);
    poke(12'h103, 16'h0104);
    poke(12'h104, 16'h1234);
    poke(12'h105, 16'h7FFF);
    poke(12'h106, 16'h00AA);
    poke(12'h110, 16'h0000);
    poke(12'h111, 16'h0000);

    @(negedge clk);
    bd_addr = 12'h105;
    #1 chk("R12 backdoor readback", {16'h0, bd_rdata}, 32'h7FFF);
    chk("R1 halted low in reset", {31'h0, halted}, 0);
    chk("R1 out_we low in reset", {31'h0, out_we}, 0);

    // scoreboard of bytes the program must emit, in order
    expect_byte(8'h08);  // R2 R3 add
    expect_byte(8'hFE);  // R3 subtract wraps negative
    expect_byte(8'h34);  // R4 indirect add, R5 skips, R6 clear
    expect_byte(8'h34);  // R11 no-op kept AC
    expect_byte(8'hAA);  // R7 subroutine entry at X+1
    expect_byte(8'h90);  // R8 zero-extended input

    mon_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;

    while (!halted) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R10 halted stays high", {31'h0, halted}, 1);
    chk("R9 all expected bytes seen", exp_q.size(), 0);

    bd_addr = 12'h110; #1 chk("R2 store result", {16'h0, bd_rdata}, 32'hFFFE);
    bd_addr = 12'h111; #1 chk("R3 wrap add stored", {16'h0, bd_rdata}, 32'h808F);
    bd_addr = 12'h120; #1 chk("R7 return address stored", {16'h0, bd_rdata}, 32'h0012);
    bd_addr = 12'h121; #1 chk("R7 next word untouched", {16'h0, bd_rdata}, {16'h0, enc(4'h1, 12'h106)});

    // second reset drops the halted flag
    mon_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears halted", {31'h0, halted}, 0);
    chk("R1 reset clears out_we", {31'h0, out_we}, 0);
    summary();
  end

endmodule